// File: doc/BRIEF.md
# Shift-Only Five-Piece Sigmoid Approximator

This block turns a signed fixed-point activation sum into an approximate log-sigmoid value between 0 and 1. It is meant for the output stage of a hardware neuron. The transfer curve has five straight pieces:

- a flat floor at 0 for large negative inputs;
- a shallow rising lower tail;
- a steep central ramp around zero;
- a shallow upper tail that mirrors the lower one;
- a flat ceiling at exactly 1.0.

Every slope is a power of two. The datapath therefore uses only magnitude compares, a subtraction from the saturation point, fixed right shifts and a constant half offset. It needs no multiplier and no table.

A sample is presented with a one-cycle strobe. The result appears on the registered output one clock later, together with its own strobe. The input is sign-magnitude, so the lower and upper tails share one subtractor and one shifter. The upper tail is formed by reflecting the lower-tail value about 1.0. Shifts truncate toward zero.

Top module: `pwl_sigmoid5`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_y` are both 0. They stay 0 until a strobed sample is accepted after reset release.
- R2: `out_valid` is high in the cycle after `in_valid` was high at a clock edge, and low otherwise. The latency is exactly one clock.
- R3: When `in_valid` is low at a clock edge, `out_y` keeps its previous value.
- R4: `in_x[12]` is the sign, with 1 meaning negative. `in_x[11:0]` is the magnitude, with 8 fraction bits. `out_y` is unsigned with 8 fraction bits, so 1.0 is `12'h100` and 0.5 is `12'h080`.
- R5: A non-negative input with magnitude `12'h800` (8.0) or more gives `out_y = 12'h100`.
- R6: A negative input with magnitude `12'h800` or more gives `out_y = 12'h000`.
- R7: For a magnitude below `12'h199` (about 1.6), `out_y` is `12'h080 + (mag >> 2)` when the sign is clear and `12'h080 - (mag >> 2)` when it is set. Negative zero gives `12'h080`.
- R8: A negative input with magnitude in `[12'h199, 12'h800)` gives `out_y = (12'h800 - mag) >> 6`.
- R9: A non-negative input with magnitude in `[12'h199, 12'h800)` gives `out_y = 12'h100 - ((12'h800 - mag) >> 6)`.
- R10: For every magnitude, the results for the positive and the negative input sum to exactly `12'h100`.
- R11: `out_y` never exceeds `12'h100`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Strobe marking `in_x` as a sample to convert |
| in_x | input | 13 | Sign-magnitude input, 1 sign, 4 integer and 8 fraction bits |
| out_valid | output | 1 | Strobe marking `out_y` as a fresh result |
| out_y | output | 12 | Unsigned result, 4 integer and 8 fraction bits |

## Verification
Two events can coincide in one cycle: an assertion of reset and an accepted sample. The bench drives `rst_n` low while `in_valid` carries a saturating input. The reset must win, so both outputs read zero and the dropped sample never shows up after release. Back-to-back strobes also make each output update coincide with the capture of the next sample. The mirrored positive and negative pairs in the sweep are compared in consecutive cycles, and each pair must sum to 1.0.

// File: rtl/pwl_sig_pkg.sv
package pwl_sig_pkg;

  // Which straight piece of the curve a sample falls on.
  typedef enum logic [2:0] {
    SEG_NEG_FLOOR = 3'd0,
    SEG_NEG_TAIL  = 3'd1,
    SEG_NEG_RAMP  = 3'd2,
    SEG_POS_RAMP  = 3'd3,
    SEG_POS_TAIL  = 3'd4,
    SEG_POS_CEIL  = 3'd5
  } seg_e;

endpackage

// File: rtl/pwl_sig_region.sv
module pwl_sig_region
  import pwl_sig_pkg::*;
#(
  parameter int MAG_W    = 12,
  parameter int KNEE_MAG = 409,
  parameter int SAT_MAG  = 2048
) (
  input  logic             neg,
  input  logic [MAG_W-1:0] mag,
  output seg_e             seg
);

  localparam logic [MAG_W-1:0] KNEE_V = MAG_W'(KNEE_MAG);
  localparam logic [MAG_W-1:0] SAT_V  = MAG_W'(SAT_MAG);

  logic at_sat;
  logic at_tail;

  always_comb begin
    at_sat  = (mag >= SAT_V);
    at_tail = (mag >= KNEE_V);
    if (at_sat) begin
      seg = neg ? SEG_NEG_FLOOR : SEG_POS_CEIL;
    end else if (at_tail) begin
      seg = neg ? SEG_NEG_TAIL : SEG_POS_TAIL;
    end else begin
      seg = neg ? SEG_NEG_RAMP : SEG_POS_RAMP;
    end
  end

endmodule

// File: rtl/pwl_sig_tail.sv
module pwl_sig_tail #(
  parameter int MAG_W   = 12,
  parameter int OUT_W   = 12,
  parameter int SAT_MAG = 2048,
  parameter int SHIFT   = 6,
  parameter int ONE     = 256
) (
  input  logic [MAG_W-1:0] mag,
  output logic [OUT_W-1:0] low_y,
  output logic [OUT_W-1:0] high_y
);

  localparam logic [MAG_W-1:0] SAT_V = MAG_W'(SAT_MAG);
  localparam logic [OUT_W-1:0] ONE_V = OUT_W'(ONE);

  logic [MAG_W-1:0] gap;
  logic [MAG_W-1:0] step;

  always_comb begin
    gap    = SAT_V - mag;
    step   = gap >> SHIFT;
    low_y  = OUT_W'(step);
    high_y = ONE_V - low_y;
  end

endmodule

// File: rtl/pwl_sig_ramp.sv
module pwl_sig_ramp #(
  parameter int MAG_W = 12,
  parameter int OUT_W = 12,
  parameter int SHIFT = 2,
  parameter int HALF  = 128
) (
  input  logic [MAG_W-1:0] mag,
  output logic [OUT_W-1:0] down_y,
  output logic [OUT_W-1:0] up_y
);

  localparam logic [OUT_W-1:0] HALF_V = OUT_W'(HALF);

  logic [MAG_W-1:0] scaled;
  logic [OUT_W-1:0] delta;

  always_comb begin
    scaled = mag >> SHIFT;
    delta  = OUT_W'(scaled);
    down_y = HALF_V - delta;
    up_y   = HALF_V + delta;
  end

endmodule

// File: rtl/pwl_sigmoid5.sv
module pwl_sigmoid5
  import pwl_sig_pkg::*;
#(
  parameter int INT_W      = 4,
  parameter int FRAC_W     = 8,
  parameter int KNEE_MAG   = 409,
  parameter int SAT_INT    = 8,
  parameter int TAIL_SHIFT = 6,
  parameter int RAMP_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [INT_W+FRAC_W:0]   in_x,
  output logic                    out_valid,
  output logic [INT_W+FRAC_W-1:0] out_y
);

  localparam int MAG_W   = INT_W + FRAC_W;
  localparam int OUT_W   = INT_W + FRAC_W;
  localparam int ONE     = 1 << FRAC_W;
  localparam int HALF    = 1 << (FRAC_W - 1);
  localparam int SAT_MAG = SAT_INT << FRAC_W;
  localparam logic [OUT_W-1:0] ONE_V = OUT_W'(ONE);
  localparam logic [MAG_W-1:0] SAT_V = MAG_W'(SAT_MAG);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // Split the sign-magnitude input.
  logic             x_neg;
  logic [MAG_W-1:0] x_mag;

  assign x_neg = in_x[MAG_W];
  assign x_mag = in_x[MAG_W-1:0];

  seg_e             seg;
  logic [OUT_W-1:0] tail_low;
  logic [OUT_W-1:0] tail_high;
  logic [OUT_W-1:0] ramp_down;
  logic [OUT_W-1:0] ramp_up;

  pwl_sig_region #(
    .MAG_W   (MAG_W),
    .KNEE_MAG(KNEE_MAG),
    .SAT_MAG (SAT_MAG)
  ) region_i (
    .neg(x_neg),
    .mag(x_mag),
    .seg(seg)
  );

  pwl_sig_tail #(
    .MAG_W  (MAG_W),
    .OUT_W  (OUT_W),
    .SAT_MAG(SAT_MAG),
    .SHIFT  (TAIL_SHIFT),
    .ONE    (ONE)
  ) tail_i (
    .mag   (x_mag),
    .low_y (tail_low),
    .high_y(tail_high)
  );

  pwl_sig_ramp #(
    .MAG_W(MAG_W),
    .OUT_W(OUT_W),
    .SHIFT(RAMP_SHIFT),
    .HALF (HALF)
  ) ramp_i (
    .mag   (x_mag),
    .down_y(ramp_down),
    .up_y  (ramp_up)
  );

  // Next-state logic.
  logic [OUT_W-1:0] seg_y;
  logic [OUT_W-1:0] y_d;
  logic             v_d;
  logic             y_en;

  always_comb begin
    unique case (seg)
      SEG_NEG_FLOOR: seg_y = '0;
      SEG_NEG_TAIL:  seg_y = tail_low;
      SEG_NEG_RAMP:  seg_y = ramp_down;
      SEG_POS_RAMP:  seg_y = ramp_up;
      SEG_POS_TAIL:  seg_y = tail_high;
      SEG_POS_CEIL:  seg_y = ONE_V;
      default:       seg_y = '0;
    endcase
    y_en = in_valid;
    y_d  = seg_y;
    v_d  = in_valid;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= v_d;
      if (y_en) begin
        out_y <= y_d;
      end
    end
  end

  // Checks.
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(out_y));

  assert_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !x_neg && (x_mag >= SAT_V)) |=> (out_y == ONE_V));

  assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && x_neg && (x_mag >= SAT_V)) |=> (out_y == '0));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_y <= ONE_V);

endmodule

// File: tb/pwl_sigmoid5_tb_top.sv
`timescale 1ns/1ps
module pwl_sigmoid5_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [12:0] in_x;
  logic        out_valid;
  logic [11:0] out_y;

  int  checks;
  int  failures;
  bit  done;

  int    exp_y_q[$];
  bit    exp_v_q[$];
  string tag_q[$];
  int    last_y;
  int    obs_prev;
  int    obs_last;

  pwl_sigmoid5 dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_x     (in_x),
    .out_valid(out_valid),
    .out_y    (out_y)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model, written from the requirements.
  function automatic int model_y(bit neg, int mag);
    int t;
    if (mag >= 2048) return neg ? 0 : 256;
    if (mag >= 409) begin
      t = (2048 - mag) / 64;
      return neg ? t : 256 - t;
    end
    t = mag / 4;
    return neg ? 128 - t : 128 + t;
  endfunction

  function automatic string model_tag(bit neg, int mag);
    if (mag >= 2048) return neg ? "R6" : "R5";
    if (mag >= 409)  return neg ? "R8" : "R9";
    return "R7";
  endfunction

  task automatic check_pending();
    int    ey;
    bit    ev;
    string tg;
    if (exp_y_q.size() == 0) return;
    ey = exp_y_q.pop_front();
    ev = exp_v_q.pop_front();
    tg = tag_q.pop_front();
    checks++;
    if (out_valid !== ev) begin
      failures++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", (tg == "R1") ? "R1" : "R2", out_valid, ev);
    end
    checks++;
    if (int'(out_y) !== ey) begin
      failures++;
      $display("FAIL %s out_y actual=%03h expected=%03h", tg, out_y, ey);
    end
    obs_prev = obs_last;
    obs_last = int'(out_y);
  endtask

  task automatic step(bit v, bit neg, int mag, string tg_override);
    @(negedge clk);
    check_pending();
    rst_n    = 1'b1;
    in_valid = v;
    in_x     = {neg, 12'(mag)};
    if (v) begin
      last_y = model_y(neg, mag);
      tag_q.push_back(tg_override != "" ? tg_override : model_tag(neg, mag));
    end else begin
      tag_q.push_back("R3");
    end
    exp_y_q.push_back(last_y);
    exp_v_q.push_back(v);
  endtask

  task automatic reset_step(bit v, bit neg, int mag);
    @(negedge clk);
    check_pending();
    rst_n    = 1'b0;
    in_valid = v;
    in_x     = {neg, 12'(mag)};
    last_y   = 0;
    exp_y_q.push_back(0);
    exp_v_q.push_back(1'b0);
    tag_q.push_back("R1");
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_x     = '0;
    checks   = 0;
    failures = 0;
    last_y   = 0;
    obs_prev = 0;
    obs_last = 0;
    done     = 1'b0;

    // R1: reset state, then synchronised release with idle input.
    reset_step(1'b0, 1'b0, 0);
    reset_step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0, "R1");
    step(1'b0, 1'b0, 0, "R1");
    step(1'b0, 1'b0, 0, "R1");

    // R4 encoding with the lower tail at -7, then known points.
    step(1'b1, 1'b1, 12'h700, "R4");  // expect 0x004
    step(1'b1, 1'b0, 12'h700, "R9");  // expect 0x0FC
    step(1'b1, 1'b1, 12'h199, "R8");  // knee, lower tail: 0x019
    step(1'b1, 1'b0, 12'h199, "R9");  // knee, upper tail: 0x0E7
    step(1'b1, 1'b0, 12'h198, "R7");  // last ramp code: 0x0E6
    step(1'b1, 1'b1, 12'h198, "R7");  // 0x01A
    step(1'b1, 1'b0, 12'h180, "R7");  // +1.5 -> 0x0E0
    step(1'b1, 1'b1, 12'h180, "R7");  // -1.5 -> 0x020
    step(1'b1, 1'b0, 0, "R7");        // 0x080
    step(1'b1, 1'b1, 0, "R7");        // negative zero -> 0x080
    step(1'b1, 1'b0, 12'h7FF, "R9");  // just below ceiling
    step(1'b1, 1'b0, 12'h800, "R5");
    step(1'b1, 1'b0, 12'h81F, "R5");
    step(1'b1, 1'b0, 12'hFFF, "R5");
    step(1'b1, 1'b1, 12'h800, "R6");
    step(1'b1, 1'b1, 12'hFFF, "R6");
    step(1'b1, 1'b0, 12'h400, "R9");

    // R3: idle cycles hold the last result.
    step(1'b0, 1'b1, 12'h100, "");
    step(1'b0, 1'b0, 12'hFFF, "");
    step(1'b0, 1'b1, 12'hFFF, "");

    // R10/R11: mirrored pairs across the whole magnitude range.
    for (int m = 0; m < 4096; m += 37) begin
      step(1'b1, 1'b0, m, "");
      step(1'b1, 1'b1, m, "");
      step(1'b0, 1'b0, 0, "");
      checks++;
      if (obs_prev + obs_last != 256) begin
        failures++;
        $display("FAIL R10 mag=%03h sum actual=%0d expected=256", m, obs_prev + obs_last);
      end
      checks++;
      if (obs_prev > 256) begin
        failures++;
        $display("FAIL R11 mag=%03h out_y actual=%0d expected<=256", m, obs_prev);
      end
    end

    // R1 together with a strobed sample in the same cycle: reset wins.
    step(1'b1, 1'b0, 12'h300, "");
    reset_step(1'b1, 1'b0, 12'hFFF);
    reset_step(1'b1, 1'b0, 12'h900);
    step(1'b0, 1'b0, 0, "R1");
    step(1'b0, 1'b0, 0, "R1");
    step(1'b0, 1'b0, 0, "R1");
    step(1'b1, 1'b1, 12'h500, "");
    step(1'b0, 1'b0, 0, "");
    @(negedge clk);
    check_pending();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule